// File: doc/BRIEF.md
# Reverse-Link GPIO Sample Framer

This block builds the slow return-direction bit stream of a serial video link. A reference oscillator clock drives a divider that sets the bit rate (one bit every 4, 2 or 1 clock cycles). Each bit time, the framer emits one bit of a 32-bit frame. The frame carries samples of up to four general-purpose inputs, taken at the clock edge on which each bit is emitted.

A 3-bit mode request picks the frame layout. The normal layout carries one sample of each of the four inputs, and its remaining payload positions stand in for identity, capability and lock messages, which this block sends as zeros. Three high-speed layouts give up those message slots and fewer inputs in exchange for more samples per frame. A high-speed layout is only accepted while the link reports lock. All configuration inputs are taken in at frame boundaries only, so no frame mixes two formats. The layout in force is reported on `mode_eff`.

Top module: `gpio_bc_framer`

## Requirements
- R1: With `hs_force`=0, `bit_vld` pulses for one cycle every 4 clock cycles when `div_sel`=0, and every 2 cycles when `div_sel`=1.
- R2: With `hs_force`=1, `bit_vld` is high on every cycle and `div_sel` has no effect.
- R3: A frame is 32 bit-times, numbered 0 to 31. Bit 0 is always 1, and `frame_sof` is high only on the `bit_vld` cycle that carries bit 0.
- R4: In normal layout (`mode_eff`=000), bit k for k=1..4 carries input k-1, and bits 5..31 are 0.
- R5: In layout 011, bit k for k=1..24 carries input (k-1) mod 4, which gives 6 samples of each input, and bits 25..31 are 0.
- R6: In layout 010, bit k for k=1..20 carries input (k-1) mod 2, which gives 10 samples each of inputs 0 and 1, and bits 21..31 are 0.
- R7: In layout 001, the odd bits 1,3,...,29 carry input 0, which gives 15 samples, and all other payload bits are 0.
- R8: At a frame boundary, a requested layout 001, 010 or 011 is adopted only if `link_lock` is 1. Otherwise normal layout is used. `mode_eff` reports the layout in force.
- R9: `mode_req`, `div_sel`, `hs_force` and `link_lock` are sampled only in the cycle that emits bit 31. Changes at any other time do not alter `mode_eff` or the bit rate until that point.
- R10: If lock drops while a high-speed layout is active, normal layout takes over at the next boundary. The high-speed layout returns only at a boundary where lock is again 1.
- R11: The reserved requests 1xx select normal layout.
- R12: After reset, all outputs are 0. The first frame uses normal layout at divide-by-4, so the first `bit_vld` appears after the 4th rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 1 | 0: divide by 4, 1: divide by 2 |
| hs_force | input | 1 | Forces divide by 1, overrides div_sel |
| mode_req | input | 3 | Requested frame layout |
| link_lock | input | 1 | Link lock flag that gates high-speed layouts |
| gpio_in | input | 4 | General-purpose inputs to be sampled |
| ser_bit | output | 1 | Serial bit, valid while bit_vld is high |
| bit_vld | output | 1 | Bit strobe |
| frame_sof | output | 1 | High on the bit-0 strobe of each frame |
| mode_eff | output | 3 | Layout in force |

## Verification
The bench changes the layout, divider and lock mid-frame. A design that applied them at once would emit a split frame, which shows up as a wrong bit or a wrong `mode_eff`. It requests high-speed layouts with lock low and with reserved codes; a design with a weak lock gate or loose decoding would report a non-zero `mode_eff` and pack the wrong inputs. It drives `div_sel` while `hs_force` is high, to expose a priority inversion as missing strobes. It also randomises the inputs every cycle, so that a layout off by one position or pointing at the wrong input index breaks the bit-by-bit comparison.

// File: rtl/bcf_pkg.sv
package bcf_pkg;

  typedef enum logic [2:0] {
    BCM_NORMAL = 3'b000,
    BCM_FAST1  = 3'b001,
    BCM_FAST2  = 3'b010,
    BCM_FAST4  = 3'b011
  } bc_mode_e;

  typedef struct packed {
    logic       used;
    logic [1:0] idx;
  } slot_t;

  // Divider minus one: override wins over the select bit.
  function automatic logic [1:0] div_minus1(input logic hs, input logic sel);
    if (hs)       return 2'd0;
    else if (sel) return 2'd1;
    else          return 2'd3;
  endfunction

  // Layout accepted at a boundary: high-speed only while locked, 1xx -> normal.
  function automatic bc_mode_e resolve_mode(input logic [2:0] req, input logic lock);
    if (!lock || req[2]) return BCM_NORMAL;
    case (req[1:0])
      2'b01:   return BCM_FAST1;
      2'b10:   return BCM_FAST2;
      2'b11:   return BCM_FAST4;
      default: return BCM_NORMAL;
    endcase
  endfunction

  // Payload slot p (frame bit p+1) -> which input, if any, it carries.
  function automatic slot_t slot_of(input bc_mode_e m, input int p);
    slot_t s;
    s.used = 1'b0;
    s.idx  = 2'd0;
    case (m)
      BCM_FAST4: begin
        s.used = (p < 24);
        s.idx  = 2'(p % 4);
      end
      BCM_FAST2: begin
        s.used = (p < 20);
        s.idx  = 2'(p % 2);
      end
      BCM_FAST1: begin
        s.used = (p < 30) && ((p % 2) == 0);
        s.idx  = 2'd0;
      end
      default: begin
        s.used = (p < 4);
        s.idx  = 2'(p % 4);
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bcf_rate_gen.sv
module bcf_rate_gen #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= div_m1);
  assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));

endmodule

// File: rtl/bcf_cfg_latch.sv
module bcf_cfg_latch
  import bcf_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             div_sel,
  input  logic             hs_force,
  input  logic [2:0]       mode_req,
  input  logic             link_lock,
  output logic [DIV_W-1:0] div_m1,
  output bc_mode_e         mode_cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_m1   <= DIV_W'(3);
      mode_cur <= BCM_NORMAL;
    end else if (load) begin
      div_m1   <= DIV_W'(div_minus1(hs_force, div_sel));
      mode_cur <= resolve_mode(mode_req, link_lock);
    end
  end

  assert_hold_between_frames_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(mode_cur) && $stable(div_m1)));
  assert_lock_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !link_lock) |=> (mode_cur == BCM_NORMAL));
  assert_force_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && hs_force) |=> (div_m1 == '0));

endmodule

// File: rtl/bcf_slot_mux.sv
module bcf_slot_mux
  import bcf_pkg::*;
#(
  parameter int FRAME_LEN = 32,
  parameter int N_GPIO    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  bc_mode_e          mode,
  input  logic [N_GPIO-1:0] gpio_in,
  output logic              frame_last,
  output logic              ser_bit,
  output logic              bit_vld,
  output logic              frame_sof
);
  localparam int POS_W = $clog2(FRAME_LEN);

  logic [POS_W-1:0] pos;
  slot_t            cur_slot;
  logic             payload_bit;
  logic             at_marker;

  assign frame_last = (pos == POS_W'(FRAME_LEN - 1));
  assign at_marker  = (pos == '0);

  always_comb begin
    cur_slot = slot_of(mode, int'(pos) - 1);
    if (at_marker)          payload_bit = 1'b1;
    else if (cur_slot.used) payload_bit = gpio_in[cur_slot.idx];
    else                    payload_bit = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= '0;
      ser_bit   <= 1'b0;
      bit_vld   <= 1'b0;
      frame_sof <= 1'b0;
    end else begin
      bit_vld   <= tick;
      frame_sof <= tick && at_marker;
      if (tick) begin
        ser_bit <= payload_bit;
        pos     <= frame_last ? '0 : pos + 1'b1;
      end
    end
  end

  assert_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sof |-> (ser_bit && bit_vld));
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frame_last) |=> (pos == '0));

endmodule

// File: rtl/gpio_bc_framer.sv
module gpio_bc_framer
  import bcf_pkg::*;
#(
  parameter int FRAME_LEN = 32,
  parameter int N_GPIO    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_sel,
  input  logic              hs_force,
  input  logic [2:0]        mode_req,
  input  logic              link_lock,
  input  logic [N_GPIO-1:0] gpio_in,
  output logic              ser_bit,
  output logic              bit_vld,
  output logic              frame_sof,
  output logic [2:0]        mode_eff
);
  localparam int DIV_W = 2;

  logic             bit_tick;
  logic             frame_last;
  logic             frame_load;
  logic [DIV_W-1:0] cfg_div_m1;
  bc_mode_e         cfg_mode;

  assign frame_load = bit_tick && frame_last;
  assign mode_eff   = cfg_mode;

  bcf_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_m1 (cfg_div_m1),
    .tick   (bit_tick)
  );

  bcf_cfg_latch #(.DIV_W(DIV_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (frame_load),
    .div_sel   (div_sel),
    .hs_force  (hs_force),
    .mode_req  (mode_req),
    .link_lock (link_lock),
    .div_m1    (cfg_div_m1),
    .mode_cur  (cfg_mode)
  );

  bcf_slot_mux #(.FRAME_LEN(FRAME_LEN), .N_GPIO(N_GPIO)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (bit_tick),
    .mode       (cfg_mode),
    .gpio_in    (gpio_in),
    .frame_last (frame_last),
    .ser_bit    (ser_bit),
    .bit_vld    (bit_vld),
    .frame_sof  (frame_sof)
  );

  assert_fast_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_div_m1 == '0) |=> bit_vld);
  assert_no_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_eff[2] == 1'b0);

endmodule

// File: tb/test_gpio_bc_framer.sv
module test_gpio_bc_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_sel = 1'b0;
  logic       hs_force = 1'b0;
  logic       link_lock = 1'b0;
  logic [2:0] mode_req = 3'd0;
  logic [3:0] gpio_in = 4'd0;
  wire        ser_bit, bit_vld, frame_sof;
  wire  [2:0] mode_eff;

  always #2 clk = ~clk;

  gpio_bc_framer i_gpio_bc_framer (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .hs_force(hs_force),
    .mode_req(mode_req), .link_lock(link_lock), .gpio_in(gpio_in),
    .ser_bit(ser_bit), .bit_vld(bit_vld), .frame_sof(frame_sof), .mode_eff(mode_eff)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: frame bit expected for a given position and layout.
  function automatic bit exp_bit(int pos, int mode, logic [3:0] g);
    int p;
    if (pos == 0) return 1'b1;
    p = pos - 1;
    case (mode)
      3: return (p / 4 < 6)  ? g[p % 4] : 1'b0;             // R5
      2: return (p / 2 < 10) ? g[p % 2] : 1'b0;             // R6
      1: return (p % 2 == 0 && p / 2 < 15) ? g[0] : 1'b0;   // R7
      default: return (p < 4) ? g[p] : 1'b0;               // R4
    endcase
  endfunction

  int    m_cnt = 0, m_div = 4, m_pos = 0, m_mode = 0;
  bit    e_vld = 0, e_bit = 0, e_sof = 0;
  string e_tag = "R4 ser_bit";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_div = 4; m_pos = 0; m_mode = 0;
      e_vld = 0; e_bit = 0; e_sof = 0;
    end else if (m_cnt == m_div - 1) begin
      e_vld = 1;
      e_sof = (m_pos == 0);
      e_bit = exp_bit(m_pos, m_mode, gpio_in);
      case (m_mode)
        3: e_tag = "R5 ser_bit";
        2: e_tag = "R6 ser_bit";
        1: e_tag = "R7 ser_bit";
        default: e_tag = "R4 ser_bit";
      endcase
      if (m_pos == 31) begin
        m_mode = (link_lock && mode_req >= 3'd1 && mode_req <= 3'd3) ? int'(mode_req) : 0;
        m_div  = hs_force ? 1 : (div_sel ? 2 : 4);
      end
      m_pos = (m_pos + 1) % 32;
      m_cnt = 0;
    end else begin
      e_vld = 0;
      e_sof = 0;
      m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(bit_vld == e_vld, (m_div == 1) ? "R2 bit_vld" : "R1 bit_vld", bit_vld, e_vld);
      chk(frame_sof == e_sof, "R3 frame_sof", frame_sof, e_sof);
      chk(ser_bit == e_bit, e_tag, ser_bit, e_bit);
      chk(mode_eff == 3'(m_mode), "R8 mode_eff", mode_eff, m_mode);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      gpio_in = 4'($urandom);
    end
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      do step(1); while (!frame_sof);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    step(3);
    chk({ser_bit, bit_vld, frame_sof} == 3'b000, "R12 reset outputs", {ser_bit, bit_vld, frame_sof}, 0);
    chk(mode_eff == 3'd0, "R12 reset mode_eff", mode_eff, 0);
    rst_n = 1'b1;
    step(3);
    chk(bit_vld == 1'b0, "R12 first strobe early", bit_vld, 0);
    step(1);
    chk(bit_vld == 1'b1 && frame_sof == 1'b1, "R12 first strobe", {bit_vld, frame_sof}, 3);
    frames(2);

    mode_req = 3'd3;                      // requested without lock
    frames(2);
    chk(mode_eff == 3'd0, "R8 no lock", mode_eff, 0);
    link_lock = 1'b1;
    frames(2);
    chk(mode_eff == 3'd3, "R8 locked", mode_eff, 3);

    mode_req = 3'd2; div_sel = 1'b1;      // just after a boundary
    step(2);
    chk(mode_eff == 3'd3, "R9 mid-frame hold", mode_eff, 3);
    frames(2);
    chk(mode_eff == 3'd2, "R9 applied at boundary", mode_eff, 2);

    hs_force = 1'b1; div_sel = 1'b0;
    frames(2);
    div_sel = 1'b1;
    frames(1);
    mode_req = 3'd1;
    frames(2);
    chk(mode_eff == 3'd1, "R7 layout active", mode_eff, 1);

    mode_req = 3'd6;
    frames(2);
    chk(mode_eff == 3'd0, "R11 reserved", mode_eff, 0);

    mode_req = 3'd3; hs_force = 1'b0; div_sel = 1'b0;
    frames(2);
    link_lock = 1'b0;
    frames(2);
    chk(mode_eff == 3'd0, "R10 lock lost", mode_eff, 0);
    link_lock = 1'b1;
    frames(2);
    chk(mode_eff == 3'd3, "R10 relock", mode_eff, 3);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

endmodule